// File: doc/BRIEF.md
# Battery Pass-Switch Protection Controller

This block decides when the switch between an energy storage rail and a battery or load may be closed. Its inputs are single-bit comparator results that the analog front end has already made: the rail is above the end-of-charge level, the rail is below that level minus its hysteresis, the rail is below the undervoltage level, the rail is at or above the rising lockout level, and the rail is below the falling lockout level. The high and low side of each hysteresis come in as separate bits. The block keeps its own decision state between those bits.

After a cold start the switch stays open and the load sees no leakage. The first end-of-charge event closes the switch and stops the converter. The converter starts again only when the rail has dropped through the hysteresis band. An undervoltage event opens the switch again, and the switch then waits for a fresh end-of-charge event. The converter's permission to run also follows a lockout latch that sets at the rising level and clears at the falling level. Both regulator enables are gated by the switch state. The two indicator outputs are active low so that they can drive open-drain pads.

Top module: `batt_pass_ctrl`

## Requirements
- R1: In reset and directly after reset: pass_close=0, conv_en=0, ldo_a_en=0, ldo_b_en=0, conn_n=1, chg_n=1. The switch stays open until an end-of-charge event is seen.
- R2: When cmp_eoc_above is high in the cold or the disconnected state, the switch closes: pass_close=1 and conn_n=0.
- R3: While connected, cmp_eoc_above high puts the block in hold: conv_en=0 and chg_n=1. Hold ends only when cmp_eoc_below_hys is high. With both end-of-charge bits low, the block stays in hold.
- R4: While connected, cmp_uvp_below high opens the switch (pass_close=0, conn_n=1). This has priority over the end-of-charge bits. The switch then stays open until cmp_eoc_above is high, even after cmp_uvp_below goes low again.
- R5: conn_n is the inverse of pass_close at all times.
- R6: ldo_a_en = ldo_a_req AND switch closed, and ldo_b_en likewise. Each is registered once, so a change of a request pin appears after one clock edge. While the switch is open, a request pin has no effect.
- R7: conv_en=1 exactly when the lockout latch is set and the block is not in end-of-charge hold. This applies in the cold, disconnected and charging states. chg_n is always the inverse of conv_en.
- R8: The lockout latch sets when cmp_uvlo_above is high and clears when cmp_uvlo_below is high. If both are high, clear wins. If both are low, the latch holds its value.
- R9: Each comparator bit passes through a two-flop synchroniser, then the state register, then the output register. A change on a comparator input therefore shows at the outputs on the fourth clock edge after it, and not on the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_eoc_above | input | 1 | Rail above end-of-charge level |
| cmp_eoc_below_hys | input | 1 | Rail below end-of-charge level minus hysteresis |
| cmp_uvp_below | input | 1 | Rail below undervoltage level |
| cmp_uvlo_above | input | 1 | Rail at or above rising lockout level |
| cmp_uvlo_below | input | 1 | Rail below falling lockout level |
| ldo_a_req | input | 1 | Request for the first regulator |
| ldo_b_req | input | 1 | Request for the second regulator |
| pass_close | output | 1 | Close command for the pass switch |
| conv_en | output | 1 | Converter switching enable |
| ldo_a_en | output | 1 | First regulator enable |
| ldo_b_en | output | 1 | Second regulator enable |
| conn_n | output | 1 | Connected indicator, low while the switch is closed |
| chg_n | output | 1 | Charging indicator, low while the converter runs |

## Verification
A comparator change reaches every output on the fourth rising edge after it is driven: two synchroniser edges, one state edge and one output edge. A regulator request reaches its enable on the first edge. The driver waits for exactly that many edges and then queues the whole expected output vector. The monitor compares each queued item at the following falling edge. One directed step samples a comparator change after three edges, where the old outputs are still expected, and again after four edges, which pins the latency from both sides.

// File: rtl/batt_pass_pkg.sv
package batt_pass_pkg;
  typedef enum logic [1:0] {
    ST_COLD      = 2'd0,
    ST_CONN_CHG  = 2'd1,
    ST_CONN_HOLD = 2'd2,
    ST_DISC      = 2'd3
  } bp_state_e;

  localparam int unsigned CMP_W = 5;
  localparam int unsigned IDX_EOC_HI = 0;
  localparam int unsigned IDX_EOC_LO = 1;
  localparam int unsigned IDX_UVP_LO = 2;
  localparam int unsigned IDX_UVLO_HI = 3;
  localparam int unsigned IDX_UVLO_LO = 4;
endpackage

// File: rtl/bp_sync.sv
module bp_sync #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= '0;
        else if (g == 0) chain[g] <= d;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/bp_lockout.sv
module bp_lockout (
  input  logic clk,
  input  logic rst,
  input  logic above_hi,
  input  logic below_lo,
  output logic run_ok
);
  always_ff @(posedge clk) begin
    if (rst)           run_ok <= 1'b0;
    else if (below_lo) run_ok <= 1'b0;
    else if (above_hi) run_ok <= 1'b1;
  end
endmodule

// File: rtl/bp_fsm.sv
module bp_fsm
  import batt_pass_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      eoc_hi,
  input  logic      eoc_lo,
  input  logic      uvp_lo,
  output bp_state_e state
);
  bp_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_COLD:      if (eoc_hi) nxt = ST_CONN_HOLD;
      ST_CONN_CHG:  if (uvp_lo) nxt = ST_DISC;
                    else if (eoc_hi) nxt = ST_CONN_HOLD;
      ST_CONN_HOLD: if (uvp_lo) nxt = ST_DISC;
                    else if (eoc_lo) nxt = ST_CONN_CHG;
      ST_DISC:      if (eoc_hi) nxt = ST_CONN_HOLD;
      default:      nxt = ST_COLD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_COLD;
    else     state <= nxt;
  end
endmodule

// File: rtl/batt_pass_ctrl.sv
module batt_pass_ctrl
  import batt_pass_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cmp_eoc_above,
  input  logic cmp_eoc_below_hys,
  input  logic cmp_uvp_below,
  input  logic cmp_uvlo_above,
  input  logic cmp_uvlo_below,
  input  logic ldo_a_req,
  input  logic ldo_b_req,
  output logic pass_close,
  output logic conv_en,
  output logic ldo_a_en,
  output logic ldo_b_en,
  output logic conn_n,
  output logic chg_n
);
  logic [CMP_W-1:0] cmp_raw;
  logic [CMP_W-1:0] cmp_s;
  bp_state_e        state_q;
  logic             run_ok;
  logic             closed;
  logic             run_now;

  assign cmp_raw[IDX_EOC_HI]  = cmp_eoc_above;
  assign cmp_raw[IDX_EOC_LO]  = cmp_eoc_below_hys;
  assign cmp_raw[IDX_UVP_LO]  = cmp_uvp_below;
  assign cmp_raw[IDX_UVLO_HI] = cmp_uvlo_above;
  assign cmp_raw[IDX_UVLO_LO] = cmp_uvlo_below;

  bp_sync #(.WIDTH(CMP_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (cmp_raw),
    .q   (cmp_s)
  );

  bp_lockout u_lockout (
    .clk      (clk),
    .rst      (rst),
    .above_hi (cmp_s[IDX_UVLO_HI]),
    .below_lo (cmp_s[IDX_UVLO_LO]),
    .run_ok   (run_ok)
  );

  bp_fsm u_fsm (
    .clk    (clk),
    .rst    (rst),
    .eoc_hi (cmp_s[IDX_EOC_HI]),
    .eoc_lo (cmp_s[IDX_EOC_LO]),
    .uvp_lo (cmp_s[IDX_UVP_LO]),
    .state  (state_q)
  );

  assign closed  = (state_q == ST_CONN_CHG) || (state_q == ST_CONN_HOLD);
  assign run_now = run_ok && (state_q != ST_CONN_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      pass_close <= 1'b0;
      conn_n     <= 1'b1;
      conv_en    <= 1'b0;
      chg_n      <= 1'b1;
      ldo_a_en   <= 1'b0;
      ldo_b_en   <= 1'b0;
    end else begin
      pass_close <= closed;
      conn_n     <= ~closed;
      conv_en    <= run_now;
      chg_n      <= ~run_now;
      ldo_a_en   <= ldo_a_req & closed;
      ldo_b_en   <= ldo_b_req & closed;
    end
  end
endmodule

// File: rtl/batt_pass_chk.sv
module batt_pass_chk
  import batt_pass_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input bp_state_e state_q,
  input logic      s_eoc_hi,
  input logic      s_uvp_lo,
  input logic      run_ok,
  input logic      pass_close,
  input logic      conv_en,
  input logic      ldo_a_en,
  input logic      ldo_b_en,
  input logic      conn_n,
  input logic      chg_n
);
  AST_CLOSE_AFTER_EOC: assert property (@(posedge clk) disable iff (rst)
    $rose(pass_close) |-> $past(s_eoc_hi, 2)); // R2
  AST_HOLD_STOPS_CONV: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CONN_HOLD) |=> !conv_en); // R3
  AST_OPEN_AFTER_UVP: assert property (@(posedge clk) disable iff (rst)
    $fell(pass_close) |-> $past(s_uvp_lo, 2)); // R4
  AST_CONN_INVERSE: assert property (@(posedge clk) disable iff (rst)
    conn_n == !pass_close); // R5
  AST_LDO_NEEDS_SWITCH: assert property (@(posedge clk) disable iff (rst)
    (ldo_a_en || ldo_b_en) |-> pass_close); // R6
  AST_CHG_INVERSE: assert property (@(posedge clk) disable iff (rst)
    chg_n == !conv_en); // R7
  AST_LOCKOUT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    !run_ok |=> !conv_en); // R8
endmodule

bind batt_pass_ctrl batt_pass_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .state_q    (state_q),
  .s_eoc_hi   (cmp_s[batt_pass_pkg::IDX_EOC_HI]),
  .s_uvp_lo   (cmp_s[batt_pass_pkg::IDX_UVP_LO]),
  .run_ok     (run_ok),
  .pass_close (pass_close),
  .conv_en    (conv_en),
  .ldo_a_en   (ldo_a_en),
  .ldo_b_en   (ldo_b_en),
  .conn_n     (conn_n),
  .chg_n      (chg_n)
);

// File: tb/batt_pass_ctrl_tb_top.sv
`timescale 1ns/1ps
module batt_pass_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic eoc_hi = 0, eoc_lo = 0, uvp_lo = 0, uvlo_hi = 0, uvlo_lo = 0;
  logic req_a = 0, req_b = 0;
  logic pass_close, conv_en, ldo_a_en, ldo_b_en, conn_n, chg_n;

  always #2.5 clk = ~clk;

  batt_pass_ctrl dut_i (
    .clk(clk), .rst(rst),
    .cmp_eoc_above(eoc_hi), .cmp_eoc_below_hys(eoc_lo), .cmp_uvp_below(uvp_lo),
    .cmp_uvlo_above(uvlo_hi), .cmp_uvlo_below(uvlo_lo),
    .ldo_a_req(req_a), .ldo_b_req(req_b),
    .pass_close(pass_close), .conv_en(conv_en), .ldo_a_en(ldo_a_en),
    .ldo_b_en(ldo_b_en), .conn_n(conn_n), .chg_n(chg_n)
  );

  typedef struct {
    logic [5:0] v;   // pass, conv, ldo_a, ldo_b, conn_n, chg_n
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Expected vector from the requirements; conn_n and chg_n follow R5 and R7.
  function automatic logic [5:0] mk(logic p, logic c, logic a, logic b);
    return {p, c, a, b, ~p, ~c};
  endfunction

  task automatic expect_after(int edges, logic [5:0] v, string tag);
    exp_t e;
    repeat (edges) @(posedge clk);
    @(negedge clk);
    e.v = v;
    e.tag = tag;
    exp_q.push_back(e);
    #2;
  endtask

  // Monitor: pops queued items shortly after the falling edge.
  always @(negedge clk) begin
    #1;
    while (exp_q.size() > 0) begin
      exp_t e;
      logic [5:0] act;
      e = exp_q.pop_front();
      act = {pass_close, conv_en, ldo_a_en, ldo_b_en, conn_n, chg_n};
      checks++;
      if (act !== e.v) begin
        errors++;
        $display("FAIL %s: actual %b expected %b", e.tag, act, e.v);
      end
    end
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    expect_after(0, mk(0,0,0,0), "R1 in reset");
    @(negedge clk); rst = 0;
    expect_after(1, mk(0,0,0,0), "R1 after reset");

    @(negedge clk); uvlo_hi = 1;
    expect_after(4, mk(0,1,0,0), "R7 cold converter runs");

    @(negedge clk); req_a = 1;
    expect_after(2, mk(0,1,0,0), "R6 request ignored while open");

    @(negedge clk); eoc_hi = 1;
    expect_after(3, mk(0,1,0,0), "R9 no change after three edges");
    expect_after(1, mk(1,0,1,0), "R2 R9 close at end of charge");

    @(negedge clk); eoc_hi = 0;
    expect_after(6, mk(1,0,1,0), "R3 inside hysteresis stays in hold");

    @(negedge clk); eoc_lo = 1;
    expect_after(4, mk(1,1,1,0), "R3 leave hold below hysteresis");

    @(negedge clk); req_b = 1;
    expect_after(1, mk(1,1,1,1), "R6 request reaches enable in one edge");

    @(negedge clk); uvlo_hi = 0; uvlo_lo = 1;
    expect_after(4, mk(1,0,1,1), "R8 lockout low stops converter");
    @(negedge clk); uvlo_lo = 0;
    expect_after(5, mk(1,0,1,1), "R8 latch holds with both bits low");
    @(negedge clk); uvlo_hi = 1; uvlo_lo = 1;
    expect_after(5, mk(1,0,1,1), "R8 clear wins when both high");
    @(negedge clk); uvlo_lo = 0;
    expect_after(4, mk(1,1,1,1), "R8 lockout high restarts converter");

    @(negedge clk); uvp_lo = 1;
    expect_after(4, mk(0,1,0,0), "R4 undervoltage opens switch");
    @(negedge clk); uvp_lo = 0;
    expect_after(6, mk(0,1,0,0), "R4 stays open without end of charge");
    @(negedge clk); req_a = 0;
    expect_after(2, mk(0,1,0,0), "R6 open switch keeps enables low");

    @(negedge clk); eoc_lo = 0; eoc_hi = 1;
    expect_after(4, mk(1,0,0,1), "R2 reconnect at next end of charge");

    @(negedge clk); uvp_lo = 1;
    expect_after(4, mk(0,1,0,0), "R4 undervoltage wins over end of charge in hold");

    @(negedge clk); rst = 1;
    expect_after(1, mk(0,0,0,0), "R1 reset returns to cold");

    repeat (4) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule